// File: doc/BRIEF.md
# Edge/Level Configurable Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor on two request lines. Each source has its own trigger mode: rising edge, falling edge, either edge, active-high level, active-low level, or off. Software sets the mode and the routing through a small register bus. Every control plane is a bit vector with one bit per source. Each plane has a set address and a clear address, so one source can be changed without a read-modify-write of its neighbours.

Edge events are captured in two sticky status planes, one for rising and one for falling edges. Software acknowledges them by writing ones to the matching status address. Level sources are not captured: they stay pending only while the input holds its active level. A per-source mask gates the sources into two pending registers, one for each request line. A separate wake-enable plane drives a wake output that does not depend on the mask.

Top module: `irqc_top`

## Requirements
- R1: Control planes sit at set/clear address pairs: trigger bit 0 at 0x00/0x01, trigger bit 1 at 0x02/0x03, trigger bit 2 at 0x04/0x05, mask at 0x06/0x07, wake enable at 0x08/0x09, route at 0x0A/0x0B. Writing ones to the set address sets those bits, and writing ones to the clear address clears them. Zero bits leave their sources unchanged. Reading either address of a pair returns the plane.
- R2: The trigger bits {bit2,bit1,bit0} select the mode: 001 rising edge, 010 falling edge, 011 either edge, 101 high level, 110 low level.
- R3: Code 000, and the unlisted codes 100 and 111, never make a source active, latch no edge, and put nothing in a pending register, whatever the input does.
- R4: An active, unmasked source with route bit 1 appears only in pending register 0 (read at 0x0E) and drives req0. With route bit 0 it appears only in pending register 1 (read at 0x0F) and drives req1.
- R5: A source with mask bit 0 reaches neither pending register. Clearing its mask drops the request line one clock after the write.
- R6: A pending register bit reads 1 exactly when that source is active, unmasked and routed to that line. A read of zero means nothing is pending on that line.
- R7: Rising edges are latched at 0x0C and falling edges at 0x0D, each only in a mode that selects that edge. A latch holds until a one is written to its own address.
- R8: In either-edge mode, writing a one to the bit at 0x0C or at 0x0D clears both edge latches of that source.
- R9: In level modes a source is active straight from the synchronized input, with no latching. It goes inactive two clocks after the input leaves its active level.
- R10: After reset every plane and latch is zero, and req0, req1 and wake are low.
- R11: req0 and req1 are the OR of their pending registers, registered once. An input edge is latched on the third clock after it appears, and a level becomes pending on the second.
- R12: wake is the registered OR of the active sources whose wake-enable bit is set, regardless of mask and route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Raw interrupt inputs, asynchronous |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | NSRC | Write data, one bit per source |
| bus_rdata | output | NSRC | Read data for bus_addr, combinational |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake request |

## Verification
The hardest case to reach is the either-edge source that holds both latches at once. The stimulus raises and then lowers one input, waiting long enough after each change for the synchronizer and edge stage. Both status planes then read set, and a single write to the rising-edge address must empty both. The bench also holds a masked level source active with only its wake bit enabled. This separates the wake path from the request path, which are otherwise hard to tell apart at the ports.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W = 5;
   localparam int NPLANE = 6;   // trig0, trig1, trig2, mask, wake, route

   localparam int PL_TRIG0 = 0;
   localparam int PL_TRIG1 = 1;
   localparam int PL_TRIG2 = 2;
   localparam int PL_MASK  = 3;
   localparam int PL_WAKE  = 4;
   localparam int PL_ROUTE = 5;

   localparam logic [ADDR_W-1:0] A_RISE  = 5'h0C;
   localparam logic [ADDR_W-1:0] A_FALL  = 5'h0D;
   localparam logic [ADDR_W-1:0] A_PEND0 = 5'h0E;
   localparam logic [ADDR_W-1:0] A_PEND1 = 5'h0F;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_FALL = 3'b010,
      TRIG_BOTH = 3'b011,
      TRIG_HIGH = 3'b101,
      TRIG_LOW  = 3'b110
   } trig_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int NSRC   = 32,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] din,
   output logic [NSRC-1:0] sync,
   output logic [NSRC-1:0] prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NSRC-1:0] pipe_q;
   logic [NSRC-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
         prev_q <= '0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], din};
         prev_q <= pipe_q[STAGES-1];
      end
   end

   assign sync = pipe_q[STAGES-1];
   assign prev = prev_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [NSRC-1:0]              bus_wdata,
   output logic [NPLANE-1:0][NSRC-1:0]  plane_q,
   output logic [NSRC-1:0]              rise_ack,
   output logic [NSRC-1:0]              fall_ack
);
   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * p);
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * p + 1);
      logic            hit_set, hit_clr;
      logic [NSRC-1:0] bits_q;

      assign hit_set = bus_we && (bus_addr == SET_A);
      assign hit_clr = bus_we && (bus_addr == CLR_A);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       bits_q <= '0;
         else if (hit_set) bits_q <= bits_q | bus_wdata;
         else if (hit_clr) bits_q <= bits_q & ~bus_wdata;
      end

      assign plane_q[p] = bits_q;
   end

   assign rise_ack = (bus_we && bus_addr == A_RISE) ? bus_wdata : '0;
   assign fall_ack = (bus_we && bus_addr == A_FALL) ? bus_wdata : '0;
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
   import irqc_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] trig0,
   input  logic [NSRC-1:0] trig1,
   input  logic [NSRC-1:0] trig2,
   input  logic [NSRC-1:0] sync,
   input  logic [NSRC-1:0] prev,
   input  logic [NSRC-1:0] rise_ack,
   input  logic [NSRC-1:0] fall_ack,
   output logic [NSRC-1:0] rise_q,
   output logic [NSRC-1:0] fall_q,
   output logic [NSRC-1:0] active
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      trig_e code;
      logic  rise_en, fall_en, both, rise_hit, fall_hit, rise_clr, fall_clr;
      logic  r_q, f_q, act;

      assign code     = trig_e'({trig2[i], trig1[i], trig0[i]});
      assign both     = (code == TRIG_BOTH);
      assign rise_en  = (code == TRIG_RISE) || both;
      assign fall_en  = (code == TRIG_FALL) || both;
      assign rise_hit = rise_en && sync[i] && !prev[i];
      assign fall_hit = fall_en && !sync[i] && prev[i];
      assign rise_clr = rise_ack[i] || (both && fall_ack[i]);
      assign fall_clr = fall_ack[i] || (both && rise_ack[i]);

      // a new edge in the acknowledge cycle wins over the clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= 1'b0;
            f_q <= 1'b0;
         end else begin
            r_q <= rise_hit || (r_q && !rise_clr);
            f_q <= fall_hit || (f_q && !fall_clr);
         end
      end

      always_comb begin
         case (code)
            TRIG_RISE: act = r_q;
            TRIG_FALL: act = f_q;
            TRIG_BOTH: act = r_q || f_q;
            TRIG_HIGH: act = sync[i];
            TRIG_LOW:  act = !sync[i];
            default:   act = 1'b0;
         endcase
      end

      assign rise_q[i] = r_q;
      assign fall_q[i] = f_q;
      assign active[i] = act;

      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (code != TRIG_RISE && code != TRIG_FALL && code != TRIG_BOTH &&
          code != TRIG_HIGH && code != TRIG_LOW) |-> !act); // R3
      AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (r_q && !rise_clr) |=> r_q); // R7
      AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (f_q && !fall_clr) |=> f_q); // R7
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic              bus_we,
   input  logic [4:0]        bus_addr,
   input  logic [NSRC-1:0]   bus_wdata,
   output logic [NSRC-1:0]   bus_rdata,
   output logic              req0,
   output logic              req1,
   output logic              wake
);
   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("irqc_top: NSRC must lie in 1..32");
   end

   logic [NPLANE-1:0][NSRC-1:0] plane_q;
   logic [NSRC-1:0] rise_ack, fall_ack, sync, prev, rise_q, fall_q, active;
   logic [NSRC-1:0] mask_q, route_q, wake_en_q, pend0, pend1, wake_src;

   irqc_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(src_in), .sync(sync), .prev(prev));

   irqc_regs #(.NSRC(NSRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .plane_q(plane_q),
      .rise_ack(rise_ack), .fall_ack(fall_ack));

   irqc_trigger #(.NSRC(NSRC)) u_trig (
      .clk(clk), .rst_n(rst_n),
      .trig0(plane_q[PL_TRIG0]), .trig1(plane_q[PL_TRIG1]), .trig2(plane_q[PL_TRIG2]),
      .sync(sync), .prev(prev), .rise_ack(rise_ack), .fall_ack(fall_ack),
      .rise_q(rise_q), .fall_q(fall_q), .active(active));

   assign mask_q    = plane_q[PL_MASK];
   assign route_q   = plane_q[PL_ROUTE];
   assign wake_en_q = plane_q[PL_WAKE];
   assign pend0     = active & mask_q & route_q;
   assign pend1     = active & mask_q & ~route_q;
   assign wake_src  = active & wake_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req0 <= 1'b0;
         req1 <= 1'b0;
         wake <= 1'b0;
      end else begin
         req0 <= |pend0;
         req1 <= |pend1;
         wake <= |wake_src;
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NPLANE; p++) begin
         if (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'(p)) bus_rdata = plane_q[p];
      end
      case (bus_addr)
         A_RISE:  bus_rdata = rise_q;
         A_FALL:  bus_rdata = fall_q;
         A_PEND0: bus_rdata = pend0;
         A_PEND1: bus_rdata = pend1;
         default: ;
      endcase
   end

   AST_MASKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> (!req0 && !req1)); // R5
   AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend0 & pend1) == '0)); // R4
   AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_en_q == '0) |=> !wake); // R12
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (active == '0) |=> (!req0 && !req1 && !wake)); // R11
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req0, req1, wake;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // scoreboard queues: kind 0 = read data, kind 1 = {req0,req1,wake}
   int          q_kind[$];
   logic [31:0] q_val[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irqc_top u_irqc_top (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req0(req0), .req1(req1), .wake(wake));

   // monitor: compares the oldest expected item at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q_kind.size() > 0) begin
            int          k;
            logic [31:0] v, got;
            string       t;
            k = q_kind.pop_front();
            v = q_val.pop_front();
            t = q_tag.pop_front();
            got = (k == 0) ? bus_rdata : {29'd0, req0, req1, wake};
            n_total++;
            if (got !== v) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, got, v);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic exp_rd(input logic [4:0] a, input logic [31:0] v, input string t);
      bus_addr = a;
      q_kind.push_back(0); q_val.push_back(v); q_tag.push_back(t);
      tick(1);
   endtask

   task automatic exp_out(input logic [2:0] v, input string t);
      q_kind.push_back(1); q_val.push_back({29'd0, v}); q_tag.push_back(t);
      tick(1);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R10 reset state
      exp_out(3'b000, "R10 outputs after reset");
      exp_rd(5'h06, 32'h0, "R10 mask plane after reset");
      exp_rd(5'h0C, 32'h0, "R10 rise latches after reset");

      // R1 per-bit set and clear
      wr(5'h00, 32'h0000_00F0);
      wr(5'h00, 32'h0000_0003);
      exp_rd(5'h00, 32'h0000_00F3, "R1 set accumulates");
      wr(5'h01, 32'h0000_0010);
      exp_rd(5'h01, 32'h0000_00E3, "R1 clear touches one bit");
      wr(5'h01, 32'hFFFF_FFFF);
      exp_rd(5'h00, 32'h0, "R1 clear all");

      // R9 / R11 high level on source 3, routed to req0
      wr(5'h04, 32'h8); wr(5'h00, 32'h8); wr(5'h0A, 32'h8); wr(5'h06, 32'h8);
      src_in[3] = 1'b1;
      tick(2);
      exp_rd(5'h0E, 32'h8, "R9 level pending after two clocks");
      exp_out(3'b100, "R11 req0 one clock after pending");
      src_in[3] = 1'b0;
      tick(2);
      exp_rd(5'h0E, 32'h0, "R9 level not latched");
      exp_out(3'b000, "R11 req0 drops");

      // R5 mask gating
      src_in[3] = 1'b1;
      tick(2);
      exp_rd(5'h0E, 32'h8, "R6 pending with mask set");
      wr(5'h07, 32'h8);
      exp_rd(5'h0E, 32'h0, "R5 masked source not pending");
      exp_out(3'b000, "R5 request gone after mask clear");

      // R12 wake independent of mask
      wr(5'h08, 32'h8);
      tick(1);
      exp_out(3'b001, "R12 wake from masked active source");
      wr(5'h09, 32'h8);
      tick(1);
      exp_out(3'b000, "R12 wake off after enable clear");

      // R4 routing to line 1
      wr(5'h0B, 32'h8); wr(5'h06, 32'h8);
      exp_rd(5'h0F, 32'h8, "R4 route 0 lands in pending 1");
      exp_rd(5'h0E, 32'h0, "R4 route 0 absent from pending 0");
      exp_out(3'b010, "R4 req1 only");
      src_in[3] = 1'b0;
      wr(5'h05, 32'hFFFF_FFFF); wr(5'h01, 32'hFFFF_FFFF);
      tick(3);

      // R2 low level on source 5, route 0 -> req1
      wr(5'h06, 32'h20); wr(5'h04, 32'h20); wr(5'h02, 32'h20);
      exp_rd(5'h0F, 32'h20, "R2 low level active on low input");
      exp_out(3'b010, "R2 low level drives req1");
      src_in[5] = 1'b1;
      tick(2);
      exp_rd(5'h0F, 32'h0, "R2 low level inactive on high input");
      exp_out(3'b000, "R2 req1 drops");
      wr(5'h05, 32'hFFFF_FFFF); wr(5'h03, 32'hFFFF_FFFF);

      // R7 rising edge on source 7, route 1
      wr(5'h0A, 32'h80); wr(5'h06, 32'h80); wr(5'h00, 32'h80);
      src_in[7] = 1'b1;
      tick(3);
      exp_rd(5'h0C, 32'h80, "R7 rise latched on third clock");
      exp_out(3'b100, "R2 rising mode drives req0");
      src_in[7] = 1'b0;
      tick(3);
      exp_rd(5'h0D, 32'h0, "R7 rise mode ignores falling edge");
      exp_rd(5'h0E, 32'h80, "R7 latch holds after input falls");
      wr(5'h0C, 32'h80);
      exp_rd(5'h0C, 32'h0, "R7 rise latch cleared");
      exp_out(3'b000, "R7 req0 drops after acknowledge");

      // R7 falling edge on source 9, route 0
      wr(5'h06, 32'h200); wr(5'h02, 32'h200);
      src_in[9] = 1'b1;
      tick(3);
      exp_rd(5'h0D, 32'h0, "R2 fall mode ignores rising edge");
      exp_rd(5'h0F, 32'h0, "R2 fall mode not pending on rise");
      src_in[9] = 1'b0;
      tick(3);
      exp_rd(5'h0D, 32'h200, "R7 fall latched");
      exp_rd(5'h0C, 32'h0, "R7 rise plane untouched by fall");
      exp_out(3'b010, "R2 falling mode drives req1");
      wr(5'h0D, 32'h200);
      exp_rd(5'h0D, 32'h0, "R7 fall latch cleared");

      // R8 both edges on source 11, route 1
      wr(5'h0A, 32'h800); wr(5'h06, 32'h800); wr(5'h00, 32'h800); wr(5'h02, 32'h800);
      src_in[11] = 1'b1;
      tick(3);
      src_in[11] = 1'b0;
      tick(3);
      exp_rd(5'h0C, 32'h800, "R8 rise latched in both mode");
      exp_rd(5'h0D, 32'h800, "R8 fall latched in both mode");
      exp_out(3'b100, "R2 both mode drives req0");
      wr(5'h0C, 32'h800);
      exp_rd(5'h0D, 32'h0, "R8 one acknowledge clears fall latch");
      exp_rd(5'h0C, 32'h0, "R8 one acknowledge clears rise latch");
      exp_rd(5'h0E, 32'h0, "R8 nothing pending after acknowledge");

      // R3 disabled and unlisted codes on source 13
      wr(5'h06, 32'h2000); wr(5'h0A, 32'h2000);
      src_in[13] = 1'b1;
      tick(3);
      exp_rd(5'h0E, 32'h0, "R3 code 000 high input not pending");
      exp_rd(5'h0C, 32'h0, "R3 code 000 latches no edge");
      src_in[13] = 1'b0;
      tick(3);
      exp_rd(5'h0D, 32'h0, "R3 code 000 latches no fall");
      wr(5'h04, 32'h2000);
      src_in[13] = 1'b1;
      tick(3);
      exp_rd(5'h0E, 32'h0, "R3 code 100 not pending");
      exp_out(3'b000, "R3 no request from disabled codes");

      tick(2);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule